// File: doc/BRIEF.md
# Wide-Line Read Prefetch Buffer

This block sits between a 32-bit system bus read port and a slow memory array that delivers 128-bit lines. It keeps four recently fetched lines, each tagged with its line address. A read whose line is already held is answered in the very next cycle, with no wait states. A read whose line is absent makes the block fetch the line from the array. The block registers the line, then returns the requested word after exactly three wait states and installs the line in the entry picked by a round-robin pointer.

The bus handshake is a single ready signal, as in a pipelined system bus. While `req_ready` is high, a request presented with `req_valid` is accepted at the clock edge. When `req_ready` is high again after that edge, `req_rdata` carries the answer. A `flush` pulse empties the buffer so that later reads go back to the array.

Top module: `line_prefetch_buf`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1, `arr_req` is 0, `req_rdata` is 0 and no entry is valid, so the first read of any line misses.
- R2: A request accepted while its line is held keeps `req_ready` at 1. In the following cycle it places on `req_rdata` the 32-bit word chosen by address bits [3:2], where word w occupies line bits [32w+31:32w]. It raises no array fetch.
- R3: A request that misses drives `req_ready` low for exactly three cycles, then high with the requested word on `req_rdata`. It raises `arr_req` for one cycle, in the cycle right after acceptance, with `arr_addr` equal to address bits [31:4].
- R4: The array must present the line on `arr_rdata` in the cycle after `arr_req` is high. The block captures it from that cycle only.
- R5: After a miss completes, a read of any other word in the same line hits.
- R6: Fills go to entries 0, 1, 2, 3, 0, ... in turn from reset, whatever the hit history. The fifth distinct line therefore evicts the first one, and the entries holding other lines keep them.
- R7: A `flush` pulse while idle invalidates every entry, so the next read of a previously held line misses.
- R8: While `req_ready` is low, `req_valid` and `req_addr` are ignored. They start no fetch and do not change the pending answer.
- R9: Hits may be issued on consecutive cycles, each answered one cycle after its acceptance, in order.
- R10: A `flush` in the last cycle of a miss still returns the correct word, but the fetched line is not kept, so a repeat read of it misses.
- R11: Bus addresses are word aligned (bits [1:0] are 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all held lines |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the read |
| req_ready | output | 1 | Request accepted / previous answer valid |
| req_rdata | output | 32 | Read data |
| arr_req | output | 1 | Array line fetch strobe |
| arr_addr | output | 28 | Line address of the fetch |
| arr_rdata | input | 128 | Line from the array, one cycle after the strobe |

## Verification
Reads are tried as single isolated misses, as hits to the other words of a just-filled line, and as an unbroken run of hits on consecutive cycles. These patterns separate the zero-wait path from the three-wait path and show that pipelined answers stay in order. A sequence of five and more distinct lines, mixed with hits, tells true round-robin replacement apart from a least-recently-used policy or a fixed victim. Junk requests held on the bus during a miss, and a flush landing either while idle or exactly in the fill cycle, show whether stray inputs can disturb a pending answer or leave a line valid that should be gone.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FILL
  } lpb_state_e;
endpackage

// File: rtl/lpb_tag_array.sv
module lpb_tag_array #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 28,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0]   tags [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tags[g] == lk_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // R7: a flush leaves nothing valid
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));

  // R10: a fill coinciding with a flush is dropped
  assert_fill_dropped_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && flush) |=> !valid_q[$past(wr_idx)]);

  // R5: a completed fill is valid
  assert_fill_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> valid_q[$past(wr_idx)]);

  // R6: a line is never held twice
  assert_single_match_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/lpb_line_store.sv
module lpb_line_store #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 128,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WPL    = LINE_W / WORD_W,
  localparam int OFF_W  = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              byp_en,
  input  logic [OFF_W-1:0]  byp_off,
  output logic [WORD_W-1:0] rdata
);
  logic [LINE_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (byp_en) begin
      rdata <= wr_line[byp_off*WORD_W +: WORD_W];
    end else if (rd_en) begin
      rdata <= mem[rd_idx][rd_off*WORD_W +: WORD_W];
    end
  end

  // R9: hit reads never collide with a fill answer
  assert_port_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && byp_en));

  // R3: the miss answer comes from the line being installed
  assert_bypass_fill_R3: assert property (@(posedge clk) disable iff (rst)
    byp_en |-> wr_en);
endmodule

// File: rtl/lpb_ctrl.sv
module lpb_ctrl
  import lpb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 28,
  parameter int LINE_W  = 128,
  parameter int OFF_W   = 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              hit,
  input  logic [LINE_W-1:0] arr_rdata,
  output logic              ready,
  output logic              arr_req,
  output logic [TAG_W-1:0]  miss_tag,
  output logic [OFF_W-1:0]  miss_off,
  output logic [LINE_W-1:0] line_q,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx
);
  lpb_state_e       st;
  logic [IDX_W-1:0] rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ready    <= 1'b1;
      arr_req  <= 1'b0;
      miss_tag <= '0;
      miss_off <= '0;
      line_q   <= '0;
      rr_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid && !hit) begin
            miss_tag <= req_tag;
            miss_off <= req_off;
            ready    <= 1'b0;
            arr_req  <= 1'b1;
            st       <= ST_REQ;
          end
        end
        ST_REQ: begin
          arr_req <= 1'b0;
          st      <= ST_WAIT;
        end
        ST_WAIT: begin
          line_q <= arr_rdata;
          st     <= ST_FILL;
        end
        ST_FILL: begin
          ready <= 1'b1;
          rr_q  <= (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign fill_en  = (st == ST_FILL);
  assign fill_idx = rr_q;

  // R3: exactly three wait states after a miss is taken
  assert_three_waits_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |=> !ready ##1 !ready ##1 ready);

  // R3: the fetch strobe is a single-cycle pulse
  assert_arr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    arr_req |=> !arr_req);

  // R2: no fetch while the bus is being served
  assert_no_fetch_ready_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> !arr_req);

  // R8: the pending miss address is frozen while ready is low
  assert_hold_miss_R8: assert property (@(posedge clk) disable iff (rst)
    (!ready && !$rose(arr_req)) |-> ($stable(miss_tag) && $stable(miss_off)));

  // R6: the victim pointer moves only on a fill
  assert_rr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !fill_en |=> $stable(rr_q));
endmodule

// File: rtl/line_prefetch_buf.sv
module line_prefetch_buf #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int LINE_W  = 128,
  parameter int ENTRIES = 4,
  localparam int WPL    = LINE_W / WORD_W,
  localparam int OFF_W  = (WPL > 1) ? $clog2(WPL) : 1,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int TAG_LO = OFF_W + BYTE_W,
  localparam int TAG_W  = ADDR_W - TAG_LO,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [WORD_W-1:0] req_rdata,
  output logic              arr_req,
  output logic [TAG_W-1:0]  arr_addr,
  input  logic [LINE_W-1:0] arr_rdata
);
  logic [TAG_W-1:0]  lk_tag;
  logic [OFF_W-1:0]  lk_off;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              rd_en;
  logic [OFF_W-1:0]  miss_off;
  logic [LINE_W-1:0] line_q;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;

  assign lk_tag = req_addr[ADDR_W-1:TAG_LO];
  assign lk_off = req_addr[TAG_LO-1:BYTE_W];
  assign rd_en  = req_valid && req_ready && hit;

  lpb_tag_array #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .lk_tag  (lk_tag),
    .hit     (hit),
    .hit_idx (hit_idx),
    .wr_en   (fill_en),
    .wr_idx  (fill_idx),
    .wr_tag  (arr_addr)
  );

  lpb_ctrl #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .LINE_W  (LINE_W),
    .OFF_W   (OFF_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_tag   (lk_tag),
    .req_off   (lk_off),
    .hit       (hit),
    .arr_rdata (arr_rdata),
    .ready     (req_ready),
    .arr_req   (arr_req),
    .miss_tag  (arr_addr),
    .miss_off  (miss_off),
    .line_q    (line_q),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx)
  );

  lpb_line_store #(
    .ENTRIES (ENTRIES),
    .LINE_W  (LINE_W),
    .WORD_W  (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fill_en),
    .wr_idx  (fill_idx),
    .wr_line (line_q),
    .rd_en   (rd_en),
    .rd_idx  (hit_idx),
    .rd_off  (lk_off),
    .byp_en  (fill_en),
    .byp_off (miss_off),
    .rdata   (req_rdata)
  );

  // R11: bus reads are word aligned
  assert_aligned_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (req_addr[BYTE_W-1:0] == '0));

  // R2: a hit answers at once and keeps the bus ready
  assert_hit_no_wait_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> req_ready);
endmodule

// File: tb/line_prefetch_buf_bench.sv
`timescale 1ns/1ps
module line_prefetch_buf_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         req_ready;
  logic [31:0]  req_rdata;
  logic         arr_req;
  logic [27:0]  arr_addr;
  logic [127:0] arr_rdata = '0;

  int checks = 0;
  int errors = 0;
  int arr_cnt = 0;
  logic [27:0] last_arr = '0;

  always #2.5 clk = ~clk;

  line_prefetch_buf u_line_prefetch_buf (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .req_rdata(req_rdata),
    .arr_req(arr_req), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
  );

  function automatic logic [31:0] wd(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'hA5C3_0F1E;
  endfunction

  function automatic logic [127:0] line_of(input logic [27:0] t);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = wd({t, w[1:0], 2'b00});
    return l;
  endfunction

  // array model: line valid only in the cycle after the strobe (R4)
  always @(posedge clk) begin
    if (arr_req) begin
      arr_rdata <= line_of(arr_addr);
      arr_cnt   <= arr_cnt + 1;
      last_arr  <= arr_addr;
    end else begin
      arr_rdata <= {4{32'hDEAD_BEEF}};
    end
  end

  function automatic logic [31:0] L(input int n, input int w);
    return 32'h4000_0000 + n * 32'h0001_0010 + w * 4;
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic read_chk(input logic [31:0] a, input bit miss, input string rq);
    int ws;
    int c0;
    logic a1;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    c0 = arr_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    a1 = arr_req;
    ws = 0;
    while (!req_ready && ws < 10) begin
      ws++;
      @(negedge clk);
    end
    check(rq, "wait states", ws, miss ? 3 : 0);
    check(rq, "read data", req_rdata, wd(a));
    check(rq, "fetch count", arr_cnt - c0, miss ? 1 : 0);
    check(rq, "strobe after accept", {31'd0, a1}, {31'd0, miss});
    if (miss) check(rq, "fetch address", {4'd0, last_arr}, {4'd0, a[31:4]});
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    check("R1", "strobe after reset", {31'd0, arr_req}, 32'd0);
    check("R1", "rdata after reset", req_rdata, 32'd0);
    read_chk(L(0, 0), 1'b1, "R1");
  endtask

  task automatic t_same_line();
    read_chk(L(0, 1), 1'b0, "R5");
    read_chk(L(0, 3), 1'b0, "R2");
    read_chk(L(0, 2), 1'b0, "R2");
  endtask

  task automatic t_miss();
    read_chk(L(1, 2), 1'b1, "R3");
    read_chk(L(2, 1), 1'b1, "R4");
    read_chk(L(3, 3), 1'b1, "R3");
  endtask

  task automatic t_round_robin();
    read_chk(L(0, 0), 1'b0, "R6");
    read_chk(L(4, 0), 1'b1, "R6");
    read_chk(L(1, 0), 1'b0, "R6");
    read_chk(L(0, 1), 1'b1, "R6");
    read_chk(L(2, 0), 1'b0, "R6");
    read_chk(L(1, 1), 1'b1, "R6");
    read_chk(L(4, 2), 1'b0, "R6");
  endtask

  task automatic t_flush();
    read_chk(L(3, 0), 1'b0, "R7");
    do_flush();
    read_chk(L(3, 0), 1'b1, "R7");
    read_chk(L(3, 1), 1'b0, "R7");
  endtask

  task automatic t_ignore();
    int c0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = L(5, 2);
    c0 = arr_cnt;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      req_addr = L(6, i);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", "ready after miss", {31'd0, req_ready}, 32'd1);
    check("R8", "pending answer kept", req_rdata, wd(L(5, 2)));
    check("R8", "fetch count", arr_cnt - c0, 32'd1);
    read_chk(L(6, 0), 1'b1, "R8");
  endtask

  task automatic t_back_to_back();
    logic [31:0] seq [6];
    seq[0] = L(5, 0); seq[1] = L(6, 3); seq[2] = L(3, 2);
    seq[3] = L(5, 1); seq[4] = L(6, 1); seq[5] = L(3, 3);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = seq[0];
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check("R9", "ready in run", {31'd0, req_ready}, 32'd1);
      check("R9", "run data", req_rdata, wd(seq[i-1]));
      if (i < 6) req_addr = seq[i];
      else req_valid = 1'b0;
    end
  endtask

  task automatic t_flush_fill();
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = L(7, 1);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R10", "ready after miss", {31'd0, req_ready}, 32'd1);
    check("R10", "answer despite flush", req_rdata, wd(L(7, 1)));
    read_chk(L(7, 1), 1'b1, "R10");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_same_line();
    t_miss();
    t_round_robin();
    t_flush();
    t_ignore();
    t_back_to_back();
    t_flush_fill();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule